// File: doc/BRIEF.md
# Flash Program/Erase Operation and Status Unit

This block carries out a single program or erase once an upstream command decoder has recognised a complete command. It holds a small behavioural byte array. A program clears bits in one byte. An erase fills a page, a sector or the whole array with FFh. Before any byte changes, the block applies the hardware guard pins and the software boot-block lock bits. Bytes that are protected are left alone, and the operation still completes normally without reporting an error.

After it accepts an operation, the block stays busy for a parameterised number of clock cycles, with one count for program and another for erase. A read during that time returns a status byte instead of array data. Bit 7 of the status byte is the complement of bit 7 of the data last loaded, which is 0 for any erase. Bit 6 flips on every read. When the busy time ends, reads return array contents again.

With the default geometry the address is 8 bits. Bits [7:5] select one of 8 sectors, bits [4:1] select one of 16 pages inside the sector, and bit [0] selects a byte inside the page. The top sector is E0h..FFh, and its top quarter is F8h..FFh.

Top module: `flash_opstat_unit`

## Requirements
- R1: After reset, every array byte reads FFh, `busy` is low and `rd_data` is 00h.
- R2: A program (op_kind 0) changes the addressed byte to its old value AND `op_data`. No other byte changes.
- R3: Erase sets the region to FFh and leaves every other byte unchanged. op_kind 1 erases the page (address bits above bit 0), op_kind 2 erases the sector (address bits [7:5]) and op_kind 3 erases the whole array.
- R4: `busy` rises on the cycle after an accepted request. It stays high for exactly PROG_CYC cycles for a program and ERASE_CYC cycles for an erase.
- R5: A request presented while `busy` is high is ignored. It changes neither the array nor the busy time.
- R6: A read while busy returns status. Bit 7 is the complement of bit 7 of `op_data` for a program, and 0 for an erase. Bits [5:0] are 0.
- R7: Status bit 6 reads 0 on the first status read of an operation and inverts on each further status read.
- R8: While `boot_guard_n` is low, no byte of the top sector changes, whatever the lock bits are.
- R9: While `wr_guard_n` is low, no byte outside the top sector changes.
- R10: `soft_lock_quarter` protects F8h..FFh. `soft_lock_full` protects the whole top sector.
- R11: A chip erase still clears every unprotected byte. An operation aimed only at protected bytes keeps its full busy time and leaves the array unchanged.
- R12: Once `busy` has fallen, a read returns the stored array byte, one cycle after `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_req | input | 1 | Operation request, one cycle |
| op_kind | input | 2 | 0 program, 1 page erase, 2 sector erase, 3 chip erase |
| op_addr | input | ADDR_W | Target byte address |
| op_data | input | 8 | Program data |
| soft_lock_full | input | 1 | Software lock of the whole top sector |
| soft_lock_quarter | input | 1 | Software lock of the top quarter of the top sector |
| boot_guard_n | input | 1 | Low: top sector protected |
| wr_guard_n | input | 1 | Low: all other sectors protected |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Registered read data or status |
| busy | output | 1 | Operation in progress |

## Verification
On every cycle, the assertions check these properties:
- `busy` follows an accepted request.
- The busy counter only counts down and is never reloaded mid-operation.
- Consecutive status reads alternate bit 6, and an erase status read shows bit 7 low.
- A program only clears bits.
- Neither guard pin lets a protected sector change.

Only the bench scenarios can show the following:
- The exact busy length.
- The contents of erased regions.
- The interaction of the quarter and full locks.
- Chip erase around a locked boot area.
- That an ignored request leaves the whole array intact.

The bench shows these by sweeping the full array against a model after every operation.

// File: rtl/flash_opstat_pkg.sv
package flash_opstat_pkg;
   typedef enum logic [1:0] {
      OP_PROG       = 2'd0,
      OP_ERASE_PAGE = 2'd1,
      OP_ERASE_SECT = 2'd2,
      OP_ERASE_CHIP = 2'd3
   } op_kind_e;

   localparam logic [7:0] ERASED_BYTE = 8'hFF;
endpackage

// File: rtl/flash_byte_guard.sv
module flash_byte_guard
   import flash_opstat_pkg::*;
#(
   parameter int SECT_W   = 3,
   parameter int PAGE_W   = 4,
   parameter int BYTE_W   = 1,
   parameter int BYTE_IDX = 0,
   localparam int ADDR_W  = SECT_W + PAGE_W + BYTE_W
) (
   input  op_kind_e            kind,
   input  logic [ADDR_W-1:0]   addr,
   input  logic                lock_full,
   input  logic                lock_quarter,
   input  logic                boot_guard_n,
   input  logic                wr_guard_n,
   output logic                hit,
   output logic                prot
);
   localparam logic [ADDR_W-1:0] ME = BYTE_IDX[ADDR_W-1:0];
   localparam bit IN_TOP  = &ME[ADDR_W-1 -: SECT_W];
   localparam bit IN_QTR  = IN_TOP && (&ME[ADDR_W-SECT_W-1 -: 2]);

   always_comb begin
      unique case (kind)
         OP_PROG:       hit = (addr == ME);
         OP_ERASE_PAGE: hit = (addr[ADDR_W-1:BYTE_W] == ME[ADDR_W-1:BYTE_W]);
         OP_ERASE_SECT: hit = (addr[ADDR_W-1 -: SECT_W] == ME[ADDR_W-1 -: SECT_W]);
         default:       hit = 1'b1;
      endcase
   end

   generate
      if (IN_TOP) begin : g_top
         assign prot = !boot_guard_n || lock_full || (IN_QTR && lock_quarter);
      end else begin : g_main
         assign prot = !wr_guard_n;
      end
   endgenerate
endmodule

// File: rtl/flash_busy_timer.sv
module flash_busy_timer #(
   parameter int PROG_CYC  = 5,
   parameter int ERASE_CYC = 12,
   localparam int MAX_CYC  = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC,
   localparam int CNT_W    = $clog2(MAX_CYC + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic is_erase,
   output logic busy
);
   logic [CNT_W-1:0] cnt;

   initial begin
      assert (PROG_CYC >= 1 && ERASE_CYC >= 1)
         else $error("busy timer lengths must be at least one cycle");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (start)
         cnt <= is_erase ? CNT_W'(ERASE_CYC) : CNT_W'(PROG_CYC);
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign busy = (cnt != '0);

   assert_start_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy);
   assert_no_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/flash_status_read.sv
module flash_status_read (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       is_erase,
   input  logic       prog_bit7,
   input  logic       busy,
   input  logic       rd_en,
   input  logic [7:0] arr_byte,
   output logic [7:0] rd_data
);
   logic poll_bit;
   logic tog;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         poll_bit <= 1'b1;
         tog      <= 1'b0;
         rd_data  <= 8'h00;
      end else begin
         if (start) begin
            poll_bit <= is_erase ? 1'b1 : prog_bit7;
            tog      <= 1'b0;
         end else if (rd_en && busy) begin
            tog <= ~tog;
         end
         if (rd_en)
            rd_data <= busy ? {~poll_bit, tog, 6'b000000} : arr_byte;
      end
   end

   assert_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && busy && $past(rd_en && busy)) |=> (rd_data[6] != $past(rd_data[6])));
   assert_low_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && busy) |=> (rd_data[5:0] == 6'b0));
   assert_erase_poll_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (start && is_erase) ##1 (rd_en && busy) |=> !rd_data[7]);
endmodule

// File: rtl/flash_opstat_unit.sv
module flash_opstat_unit
   import flash_opstat_pkg::*;
#(
   parameter int SECT_W    = 3,
   parameter int PAGE_W    = 4,
   parameter int BYTE_W    = 1,
   parameter int PROG_CYC  = 5,
   parameter int ERASE_CYC = 12,
   localparam int ADDR_W   = SECT_W + PAGE_W + BYTE_W,
   localparam int NBYTES   = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_req,
   input  logic [1:0]        op_kind,
   input  logic [ADDR_W-1:0] op_addr,
   input  logic [7:0]        op_data,
   input  logic              soft_lock_full,
   input  logic              soft_lock_quarter,
   input  logic              boot_guard_n,
   input  logic              wr_guard_n,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_data,
   output logic              busy
);
   op_kind_e          kind;
   logic              accept;
   logic              is_erase;
   logic [NBYTES-1:0] hit_v;
   logic [NBYTES-1:0] prot_v;
   logic [7:0]        mem [NBYTES];

   initial begin
      assert (PAGE_W >= 2) else $error("quarter lock needs at least four pages per sector");
      assert (SECT_W >= 1 && BYTE_W >= 0) else $error("bad array geometry");
      assert (ADDR_W <= 12) else $error("behavioural array too large");
   end

   assign kind     = op_kind_e'(op_kind);
   assign accept   = op_req && !busy;
   assign is_erase = (kind != OP_PROG);

   for (genvar i = 0; i < NBYTES; i++) begin : g_byte
      flash_byte_guard #(
         .SECT_W(SECT_W), .PAGE_W(PAGE_W), .BYTE_W(BYTE_W), .BYTE_IDX(i)
      ) guard_i (
         .kind(kind), .addr(op_addr),
         .lock_full(soft_lock_full), .lock_quarter(soft_lock_quarter),
         .boot_guard_n(boot_guard_n), .wr_guard_n(wr_guard_n),
         .hit(hit_v[i]), .prot(prot_v[i])
      );

      localparam logic [ADDR_W-1:0] BA = i[ADDR_W-1:0];
      localparam bit TOP = &BA[ADDR_W-1 -: SECT_W];

      if (TOP) begin : g_chk_top
         assert_boot_guard_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (accept && !boot_guard_n) |=> (mem[i] == $past(mem[i])));
      end else begin : g_chk_main
         assert_wr_guard_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (accept && !wr_guard_n) |=> (mem[i] == $past(mem[i])));
      end
      assert_prog_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (accept && kind == OP_PROG) |=> ((mem[i] & ~$past(mem[i])) == 8'h00));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int b = 0; b < NBYTES; b++) mem[b] <= ERASED_BYTE;
      end else if (accept) begin
         for (int b = 0; b < NBYTES; b++) begin
            if (hit_v[b] && !prot_v[b])
               mem[b] <= is_erase ? ERASED_BYTE : (mem[b] & op_data);
         end
      end
   end

   flash_busy_timer #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) timer_i (
      .clk(clk), .rst_n(rst_n), .start(accept), .is_erase(is_erase), .busy(busy)
   );

   flash_status_read status_i (
      .clk(clk), .rst_n(rst_n), .start(accept), .is_erase(is_erase),
      .prog_bit7(op_data[7]), .busy(busy), .rd_en(rd_en),
      .arr_byte(mem[rd_addr]), .rd_data(rd_data)
   );
endmodule

// File: tb/flash_opstat_unit_tb.sv
`timescale 1ns/1ps
module flash_opstat_unit_tb_top;
   localparam int AW = 8;
   localparam int NB = 256;
   localparam int PC = 5;
   localparam int EC = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          op_req = 1'b0;
   logic [1:0]    op_kind = 2'd0;
   logic [AW-1:0] op_addr = '0;
   logic [7:0]    op_data = 8'h00;
   logic          lk_full = 1'b0, lk_qtr = 1'b0, bg_n = 1'b1, wg_n = 1'b1;
   logic          rd_en = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic [7:0]    rd_data;
   logic          busy;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   logic [7:0] model [NB];

   always #2 clk = ~clk;

   flash_opstat_unit dut_i (
      .clk(clk), .rst_n(rst_n), .op_req(op_req), .op_kind(op_kind),
      .op_addr(op_addr), .op_data(op_data), .soft_lock_full(lk_full),
      .soft_lock_quarter(lk_qtr), .boot_guard_n(bg_n), .wr_guard_n(wg_n),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
   );

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         bad++; total++;
         $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic bit is_prot(input int a);
      bit top = (a >= 8'hE0);
      bit qtr = (a >= 8'hF8);
      if (top) return !bg_n || lk_full || (qtr && lk_qtr);
      return !wg_n;
   endfunction

   function automatic bit in_region(input int k, input int t, input int a);
      case (k)
         0: return a == t;
         1: return (a >> 1) == (t >> 1);
         2: return (a >> 5) == (t >> 5);
         default: return 1'b1;
      endcase
   endfunction

   task automatic sweep(input string req);
      int miss = 0;
      rd_en = 1'b1;
      for (int a = 0; a < NB; a++) begin
         rd_addr = a[AW-1:0];
         @(negedge clk);
         if (rd_data !== model[a]) begin
            if (miss == 0)
               $display("FAIL %s: addr %0h actual=%0h expected=%0h", req, a, rd_data, model[a]);
            miss++;
         end
      end
      rd_en = 1'b0;
      total++;
      if (miss != 0) bad++;
   endtask

   task automatic do_op(input int k, input int a, input logic [7:0] d, input string req);
      int n = 0;
      int expn = (k == 0) ? PC : EC;
      logic exp7 = (k == 0) ? ~d[7] : 1'b0;
      op_req = 1'b1; op_kind = k[1:0]; op_addr = a[AW-1:0]; op_data = d;
      for (int b = 0; b < NB; b++)
         if (in_region(k, a, b) && !is_prot(b))
            model[b] = (k == 0) ? (model[b] & d) : 8'hFF;
      @(negedge clk);
      op_req = 1'b0;
      chk(busy === 1'b1, "R4 busy after accept", busy, 1);
      if (busy) n++;
      rd_en = 1'b1; rd_addr = a[AW-1:0];
      @(negedge clk);
      if (busy) n++;
      chk(rd_data === {exp7, 7'b0}, "R6 R7 first status read", rd_data, {exp7, 7'b0});
      @(negedge clk);
      if (busy) n++;
      chk(rd_data[6] === 1'b1, "R7 second status read toggles", rd_data[6], 1);
      rd_en = 1'b0;
      op_req = 1'b1; op_kind = 2'd0; op_addr = a[AW-1:0] ^ 8'h55; op_data = 8'h00;
      @(negedge clk);
      if (busy) n++;
      op_req = 1'b0;
      while (busy) begin
         @(negedge clk);
         if (busy) n++;
      end
      chk(n == expn, "R4 R5 busy length", n, expn);
      sweep(req);
   endtask

   initial begin
      for (int b = 0; b < NB; b++) model[b] = 8'hFF;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      chk(busy === 1'b0, "R1 busy low at reset", busy, 0);
      chk(rd_data === 8'h00, "R1 rd_data at reset", rd_data, 0);
      rst_n = 1'b1;
      @(negedge clk);
      sweep("R1 array erased after reset");

      do_op(0, 8'h10, 8'hA5, "R2 program");
      do_op(0, 8'h10, 8'h3C, "R2 program ANDs bits");
      do_op(0, 8'h23, 8'h00, "R2 program zero");
      do_op(1, 8'h11, 8'h00, "R3 page erase");
      do_op(0, 8'h47, 8'h0F, "R2 program before sector erase");
      do_op(2, 8'h40, 8'h00, "R3 sector erase");
      bg_n = 1'b0;
      do_op(0, 8'hE4, 8'h00, "R8 boot guard blocks program");
      do_op(0, 8'h40, 8'h12, "R8 boot guard leaves main array");
      bg_n = 1'b1; wg_n = 1'b0;
      do_op(0, 8'h41, 8'h00, "R9 write guard blocks main array");
      do_op(0, 8'hE4, 8'h81, "R9 write guard leaves top sector");
      wg_n = 1'b1; lk_qtr = 1'b1;
      do_op(0, 8'hF9, 8'h00, "R10 quarter lock blocks");
      do_op(0, 8'hF0, 8'h00, "R10 quarter lock leaves rest");
      lk_full = 1'b1;
      do_op(0, 8'hE2, 8'h00, "R10 full lock blocks");
      lk_full = 1'b0;
      do_op(0, 8'hFE, 8'h00, "R11 protected op keeps busy time");
      do_op(0, 8'h05, 8'h00, "R11 prefill");
      do_op(3, 8'h00, 8'h00, "R11 chip erase skips locked quarter");
      lk_qtr = 1'b0;
      do_op(3, 8'h77, 8'h00, "R3 chip erase all");

      for (int i = 0; i < 45; i++) begin
         int r = $urandom;
         lk_full = (r[3:0] == 0); lk_qtr = (r[7:5] == 0);
         bg_n = (r[10:8] != 0); wg_n = (r[13:11] != 0);
         do_op((r[17:15] < 3'd5) ? 0 : int'(r[19:18]), int'(r[27:20]),
               8'($urandom), "R12 random op read back");
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule